// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel bytes into an asynchronous serial bit stream. The frame layout is set by a byte-wide line control register that software can rewrite at any time. That register sets the word length (5 to 8 bits), the parity mode (none, odd, even or stuck), the stop length (one, one and a half, or two bits) and a break control.

Bytes arrive over a valid/ready handshake. Bit timing comes from a one-cycle `baud_tick` pulse made by an external divider, and every serial bit lasts 16 ticks.

The register's top bit has no effect inside the block. It is driven out on `dl_access` so that a neighbouring address decoder can choose between divisor and data access.

Top module: `sertx_core`

## Requirements
- R1: After reset the register reads 0, `dl_access` is 0, `txd` is 1 and `tx_ready` is 1.
- R2: Register bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: Register bit 3 enables parity. When it is 0 the frame carries no parity bit, and the stop bits follow the last data bit directly.
- R4: With parity enabled and bit 5 clear, bit 4 picks the parity. When bit 4 is 1 the parity bit is the XOR of the sent data bits (even parity). When bit 4 is 0 it is the inverse of that XOR (odd parity).
- R5: When bit 5 and bit 3 are both 1, the parity bit is the inverse of bit 4, whatever the data. When bit 3 is 0, bit 5 has no effect on the frame.
- R6: Register bit 2 sets the stop length. When it is 0 the stop is 16 ticks. When it is 1 the stop is 32 ticks, except with a 5-bit word (bits [1:0] = 00), where it is 24 ticks.
- R7: Writing register bit 6 as 1 drives `txd` to 0 from the clock edge of the write onward. This also abandons any frame in progress and holds `tx_ready` low.
- R8: Clearing bit 6 returns `txd` to 1 from the clock edge of the write onward. A byte waiting on `tx_valid` is then accepted and sent as a complete new frame, starting with a fresh start bit.
- R9: Writes to bits [31:8] are ignored and those bits read 0. Bit 7 is stored and driven on `dl_access`.
- R10: The frame format is captured when a byte is accepted. Register writes during a frame, other than bit 6, do not alter that frame.
- R11: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that edge until the frame ends.
- R12: With no break active, the line idles at 1 whenever `tx_ready` is 1. A frame starts with 16 ticks at 0, followed by the data bits LSB first at 16 ticks each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_we | input | 1 | Line control register write strobe |
| lcr_wdata | input | 32 | Line control register write data |
| lcr_rdata | output | 32 | Line control register read data |
| dl_access | output | 1 | Stored bit 7, for an external address decoder |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | 8 | Byte to send; the unused high bits are ignored for short words |
| tx_ready | output | 1 | Byte can be accepted |
| txd | output | 1 | Serial line output |

## Verification
The hardest case to reach from the ports is a break that lands in the middle of a frame while another byte is already waiting. The bench starts a frame and sends some ticks so the shifter is deep inside the data bits. It then sets break and raises `tx_valid` with a new byte while `tx_ready` is low. When break is cleared, it checks that the line is high on that cycle, that the waiting byte is taken on the next edge, and that the whole following frame starts from a clean start bit.

A second case that takes some setting up is a format rewrite during a frame. The bench changes the word length, parity and stop length in the middle of a frame, then checks every tick of that frame against the format that was in force when the byte was accepted.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W = 8;
  localparam int REG_W  = 32;

  // Register layout: field positions are decoded by software and by the
  // neighbouring address decoder (dlab), so the order is fixed.
  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stop2;
    logic [1:0] wls;
  } lcr_t;

  // Format snapshot taken at the start of a frame.
  typedef struct packed {
    logic [1:0] wls;
    logic       stop2;
    logic       pen;
    logic       even;
    logic       stick;
  } fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_t;

  function automatic fmt_t fmt_of(lcr_t r);
    fmt_t f;
    f.wls   = r.wls;
    f.stop2 = r.stop2;
    f.pen   = r.pen;
    f.even  = r.even;
    f.stick = r.stick;
    return f;
  endfunction

  function automatic int data_bits(logic [1:0] wls);
    return 5 + int'(wls);
  endfunction

  function automatic logic parity_of(fmt_t f, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    logic x;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < data_bits(f.wls)) ? d[i] : 1'b0;
    x = ^m;
    if (f.stick) return ~f.even;
    return f.even ? x : ~x;
  endfunction

  function automatic int stop_ticks(fmt_t f, int tpb);
    if (!f.stop2) return tpb;
    if (f.wls == 2'b00) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/sertx_lcr.sv
module sertx_lcr #(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [FIELD_W-1:0] q,
  output logic [REG_W-1:0]   rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata[FIELD_W-1:0];
  end

  assign rdata = REG_W'(q);
endmodule

// File: rtl/sertx_tick_timer.sv
module sertx_tick_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (done)    cnt <= '0;
    else if (tick)    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int TPB = 16,
  parameter int CW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt_in,
  input  logic              bit_done,
  output logic              busy,
  output logic              line,
  output logic [CW-1:0]     limit,
  output fmt_t              fmt_q
);
  localparam int IW = $clog2(DATA_W);

  tx_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     idx;
  logic              par_q;
  logic              last_data;

  assign last_data = (idx == IW'(data_bits(fmt_q.wls) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= '0;
      idx   <= '0;
      par_q <= 1'b0;
      fmt_q <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else if (start) begin
      state <= ST_START;
      shreg <= data;
      idx   <= '0;
      fmt_q <= fmt_in;
      par_q <= parity_of(fmt_in, data);
    end else if (bit_done) begin
      unique case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          shreg <= shreg >> 1;
          if (last_data) state <= fmt_q.pen ? ST_PAR : ST_STOP;
          else           idx   <= idx + IW'(1);
        end
        ST_PAR:  state <= ST_STOP;
        ST_STOP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign limit = (state == ST_STOP) ? CW'(stop_ticks(fmt_q, TPB)) : CW'(TPB);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcr_we,
  input  logic [REG_W-1:0]  lcr_wdata,
  output logic [REG_W-1:0]  lcr_rdata,
  output logic              dl_access,
  input  logic              baud_tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);

  lcr_t          lcr_q;
  logic [7:0]    lcr_bits;
  logic          brk_on;
  logic          frame_start;
  logic          bit_done;
  logic          busy;
  logic          line;
  logic [CW-1:0] limit;
  fmt_t          fmt_q;

  sertx_lcr #(.REG_W(REG_W), .FIELD_W(8)) u_lcr (
    .clk(clk), .rst_n(rst_n), .we(lcr_we), .wdata(lcr_wdata),
    .q(lcr_bits), .rdata(lcr_rdata)
  );
  assign lcr_q = lcr_t'(lcr_bits);

  assign brk_on      = lcr_q.brk;
  assign tx_ready    = !busy && !brk_on;
  assign frame_start = tx_valid && tx_ready;

  sertx_tick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy && !brk_on), .tick(baud_tick),
    .limit(limit), .done(bit_done)
  );

  sertx_frame #(.TPB(TICKS_PER_BIT), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .abort(brk_on), .start(frame_start),
    .data(tx_data), .fmt_in(fmt_of(lcr_q)), .bit_done(bit_done),
    .busy(busy), .line(line), .limit(limit), .fmt_q(fmt_q)
  );

  assign txd       = brk_on ? 1'b0 : line;
  assign dl_access = lcr_q.dlab;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk
  import sertx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lcr_we,
  input logic [REG_W-1:0] lcr_wdata,
  input logic [REG_W-1:0] lcr_rdata,
  input logic             dl_access,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             txd,
  input logic             frame_start,
  input logic             busy,
  input fmt_t             fmt_q
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_rdata[31:8] == '0); // R9
  AST_DLAB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_we |=> dl_access == $past(lcr_wdata[7])); // R9
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_we && lcr_wdata[6]) |=> !txd && !tx_ready); // R7
  AST_UNBREAK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_we && !lcr_wdata[6] && !busy) |=> txd); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R11
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !lcr_we) |=> !txd); // R12
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd); // R12
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fmt_q)); // R10
endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
  .lcr_rdata(lcr_rdata), .dl_access(dl_access), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txd(txd), .frame_start(frame_start),
  .busy(busy), .fmt_q(fmt_q)
);

// File: tb/sertx_core_test.sv
module sertx_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcr_we = 1'b0;
  logic [31:0] lcr_wdata = '0;
  logic [31:0] lcr_rdata;
  logic        dl_access;
  logic        baud_tick = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        txd;

  int n_pass = 0;
  int n_total = 0;

  always #2 clk = ~clk;

  sertx_core uut (
    .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
    .lcr_rdata(lcr_rdata), .dl_access(dl_access), .baud_tick(baud_tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
  endtask

  // Expected model from the requirements.
  function automatic int nbits(logic [7:0] l); return 5 + int'(l[1:0]); endfunction

  function automatic logic exp_par(logic [7:0] l, logic [7:0] d);
    logic x = 1'b0;
    for (int i = 0; i < nbits(l); i++) x ^= d[i];
    if (l[5]) return ~l[4];
    return l[4] ? x : ~x;
  endfunction

  function automatic int frame_len(logic [7:0] l);
    int stop = !l[2] ? 16 : (l[1:0] == 2'b00 ? 24 : 32);
    return 16 * (1 + nbits(l) + int'(l[3])) + stop;
  endfunction

  function automatic logic exp_bit(logic [7:0] l, logic [7:0] d, int t);
    int seg = t / 16;
    if (seg == 0) return 1'b0;
    if (seg <= nbits(l)) return d[seg-1];
    if (l[3] && seg == nbits(l) + 1) return exp_par(l, d);
    return 1'b1;
  endfunction

  task automatic write_lcr(logic [31:0] v);
    @(negedge clk); lcr_we = 1'b1; lcr_wdata = v;
    @(negedge clk); lcr_we = 1'b0;
  endtask

  task automatic accept(logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pulse;
    baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  // Run ticks from just after acceptance, check the whole frame.
  // mid_tick >= 0: write mid_val into the register before that tick.
  task automatic run_frame(logic [7:0] l, logic [7:0] d, string req,
                           int mid_tick = -1, logic [31:0] mid_val = 0);
    int total = frame_len(l);
    int bad = -1;
    logic got = 1'b0;
    logic rdy_late = 1'b0;
    for (int t = 0; t < total; t++) begin
      if (t == mid_tick) begin
        lcr_we = 1'b1; lcr_wdata = mid_val;
        @(negedge clk); lcr_we = 1'b0;
      end
      if (txd !== exp_bit(l, d, t) && bad < 0) begin bad = t; got = txd; end
      if (t == total - 1) rdy_late = tx_ready;
      pulse();
    end
    check(bad < 0, req, (bad < 0) ? 0 : {got, 16'(bad)},
          (bad < 0) ? 0 : {exp_bit(l, d, bad), 16'(bad)});
    check(rdy_late == 1'b0 && tx_ready == 1'b1 && txd == 1'b1,
          {req, " length"}, {rdy_late, tx_ready, txd}, 3'b011);
  endtask

  task automatic send(logic [7:0] l, logic [7:0] d, string req);
    write_lcr({24'h0, l});
    accept(d);
    run_frame(l, d, req);
  endtask

  task automatic t_reset;
    check(lcr_rdata == 0 && dl_access == 0, "R1 register",
          {lcr_rdata, dl_access}, 0);
    check(txd == 1 && tx_ready == 1, "R1 line", {txd, tx_ready}, 2'b11);
  endtask

  task automatic t_wordlen;
    for (int w = 0; w < 4; w++) send(8'(w), 8'hB5 ^ 8'(w * 37), $sformatf("R2 R12 wls=%0d", w));
  endtask

  task automatic t_parity;
    send(8'b0000_1011, 8'h3C, "R3 R4 odd");
    send(8'b0001_1011, 8'h3D, "R3 R4 even");
    send(8'b0001_1001, 8'h15, "R4 even 6bit");
    send(8'b0000_0011, 8'hFF, "R3 parity off");
  endtask

  task automatic t_stick;
    send(8'b0010_1011, 8'hA7, "R5 stick odd");
    send(8'b0011_1010, 8'h00, "R5 stick even");
    send(8'b0010_0011, 8'h5A, "R5 stick no pen");
  endtask

  task automatic t_stop;
    send(8'b0000_0100, 8'h13, "R6 1.5 stop");
    send(8'b0000_0111, 8'hC3, "R6 2 stop");
    send(8'b0000_1101, 8'h2E, "R6 2 stop parity");
  endtask

  task automatic t_upper;
    write_lcr(32'hFFFF_FF80);
    check(lcr_rdata == 32'h80 && dl_access == 1'b1, "R9 upper/dlab",
          {lcr_rdata, dl_access}, {32'h80, 1'b1});
    write_lcr(32'h0000_0000);
    check(dl_access == 1'b0, "R9 dlab clear", dl_access, 0);
  endtask

  task automatic t_sample;
    write_lcr(32'h03);
    accept(8'h96);
    run_frame(8'h03, 8'h96, "R10 format held", 40, 32'h1C);
    write_lcr(32'h03);
  endtask

  task automatic t_handshake;
    write_lcr(32'h03);
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h11;
    @(negedge clk);
    check(tx_ready == 1'b0 && txd == 1'b0, "R11 accepted", {tx_ready, txd}, 0);
    tx_data = 8'hEE;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R11 busy", tx_ready, 0);
    run_frame(8'h03, 8'h11, "R11 first byte kept");
  endtask

  task automatic t_break;
    write_lcr(32'h03);
    accept(8'hF0);
    for (int i = 0; i < 40; i++) pulse();
    write_lcr(32'h43);
    check(txd == 1'b0 && tx_ready == 1'b0, "R7 break", {txd, tx_ready}, 0);
    tx_valid = 1'b1; tx_data = 8'h5B;
    for (int i = 0; i < 20; i++) pulse();
    check(txd == 1'b0 && tx_ready == 1'b0, "R7 break held", {txd, tx_ready}, 0);
    lcr_we = 1'b1; lcr_wdata = 32'h03;
    @(negedge clk); lcr_we = 1'b0;
    check(txd == 1'b1 && tx_ready == 1'b1, "R8 unbreak idle", {txd, tx_ready}, 2'b11);
    @(negedge clk); tx_valid = 1'b0;
    run_frame(8'h03, 8'h5B, "R8 fresh frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upper();
    t_wordlen();
    t_parity();
    t_stick();
    t_stop();
    t_sample();
    t_handshake();
    t_break();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule